// File: doc/BRIEF.md
# Processor Watchdog and Reset Generator

This block watches a processor through a kick input and a supply-valid input. It drives a timed active-low system reset and a latched watchdog-status flag. All timing is counted in ticks of a time base. The time base arrives as a single-cycle enable on the system clock, so one fast clock can stand in for any oscillator rate.

Two select inputs choose one of three timing modes. In external mode, a kick is expected every 1024 ticks in normal running and every 4096 ticks just after a reset. In internal-long mode, both windows are 16384 ticks. In internal-short mode, the window is 16384 ticks after a reset and 1024 ticks once the processor has kicked.

A missed kick pulls the status flag low and starts a reset pulse. The flag stays low until the processor kicks again. A low supply, or running on battery, is one input. While it is low, reset is held, the status flag is held high, and kicks and mode changes have no effect.

Top module: `wdt_supervisor`

## Requirements
- R1: While `supply_ok` is 0, `sys_rst_n` is 0. After `supply_ok` returns to 1, `sys_rst_n` stays 0 for exactly RST_TICKS ticks (default 512).
- R2: With `ext_base`=1, the first window after any reset is 4096 ticks. If no kick edge arrives, `wd_ok` falls exactly 4096 ticks after reset ends.
- R3: With `ext_base`=1, once a kick edge has arrived after reset, the window is 1024 ticks.
- R4: With `ext_base`=0 and `long_sel`=1, the window is 16384 ticks both after reset and after a kick.
- R5: With `ext_base`=0 and `long_sel`=0, the window is 16384 ticks after reset and 1024 ticks after the first kick edge.
- R6: A watchdog timeout pulls `sys_rst_n` to 0 in the same cycle that `wd_ok` falls. Reset then lasts RST_TICKS ticks, and the window counter is held clear during that time.
- R7: `wd_ok` stays 0 until the next kick edge, including across the reset pulse. The kick input passes through two synchronizer stages and an edge detector. As a result, `wd_ok` rises on the third clock edge after `kick_in` changes.
- R8: While `supply_ok` is 0, `wd_ok` is 1.
- R9: While `supply_ok` is 0, changes on `kick_in`, `ext_base` and `long_sel` have no effect: `sys_rst_n` stays 0 and `wd_ok` stays 1.
- R10: Both rising and falling kick edges restart the window. Alternating kicks spaced closer than the window never let `wd_ok` fall.
- R11: Counting advances only on clock edges where `tick_en` is 1. With `tick_en` high every other cycle, a reset pulse spans about 2·RST_TICKS clocks.
- R12: While `arst_n` is 0, `sys_rst_n` is 0 and `wd_ok` is 1, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| tick_en | input | 1 | Single-cycle time-base tick |
| supply_ok | input | 1 | 1 = supply valid; 0 = low supply or battery backup |
| kick_in | input | 1 | Processor kick; either edge restarts the window |
| ext_base | input | 1 | 1 = external time-base timing; 0 = internal oscillator timing |
| long_sel | input | 1 | Internal mode only: 1 = long window, 0 = short normal window |
| sys_rst_n | output | 1 | Active-low system reset |
| wd_ok | output | 1 | Watchdog status; 0 after a timeout until the next kick |

## Verification
Each result has a fixed latency in clock edges:
- Reset release: RST_TICKS edges after supply returns, or after the timeout edge.
- A timeout: exactly the window length in edges after reset release.
- A kick: three edges to raise `wd_ok`, and the window plus three edges to a later timeout.

The bench drives inputs one time unit after a rising edge. It then counts edges one by one until the output under test changes, and compares the count with the exact figures above. Only the gated-tick case allows a one-edge spread, because tick phase is not aligned to the supply edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    TB_EXT       = 2'd0,
    TB_INT_LONG  = 2'd1,
    TB_INT_SHORT = 2'd2
  } tbase_e;

  function automatic tbase_e decode_mode(input logic ext, input logic lng);
    if (ext)      return TB_EXT;
    else if (lng) return TB_INT_LONG;
    else          return TB_INT_SHORT;
  endfunction
endpackage

// File: rtl/wdt_sync_edge.sv
module wdt_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic en,
  output logic edge_o
);
  logic s1_q, s2_q, d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      d_q  <= 1'b0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
      d_q  <= s2_q;
    end
  end

  assign edge_o = (s2_q ^ d_q) & en;
endmodule

// File: rtl/wdt_rst_timer.sv
module wdt_rst_timer #(
  parameter int RST_TICKS = 512,
  localparam int RW = $clog2(RST_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hold,
  input  logic start,
  output logic active
);
  logic          act_q, act_d;
  logic [RW-1:0] cnt_q, cnt_d;

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (hold || start) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (act_q && tick) begin
      if (cnt_q == RW'(RST_TICKS - 1)) begin
        act_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  assign active = act_q;
endmodule

// File: rtl/wdt_dog.sv
module wdt_dog #(
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          supply_ok,
  input  logic          rst_act,
  input  logic          kick_edge,
  input  logic [CW-1:0] lim_post,
  input  logic [CW-1:0] lim_norm,
  output logic          timeout,
  output logic          wd_ok,
  output logic [CW-1:0] count_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          post_q, post_d;
  logic          ok_q, ok_d;
  logic [CW-1:0] lim;

  assign lim     = post_q ? lim_post : lim_norm;
  assign timeout = supply_ok && !rst_act && !kick_edge && tick &&
                   (cnt_q == lim - CW'(1));

  always_comb begin
    cnt_d  = cnt_q;
    post_d = post_q;
    if (!supply_ok || rst_act) begin
      cnt_d  = '0;
      post_d = 1'b1;
    end else if (kick_edge) begin
      cnt_d  = '0;
      post_d = 1'b0;
    end else if (tick) begin
      cnt_d = timeout ? '0 : cnt_q + 1'b1;
    end

    ok_d = ok_q;
    if (!supply_ok)     ok_d = 1'b1;
    else if (timeout)   ok_d = 1'b0;
    else if (kick_edge) ok_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      post_q <= 1'b1;
      ok_q   <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      post_q <= post_d;
      ok_q   <= ok_d;
    end
  end

  assign wd_ok   = ok_q;
  assign count_o = cnt_q;
endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor #(
  parameter int RST_TICKS = 512,
  parameter int EXT_NORM  = 1024,
  parameter int EXT_POST  = 4096,
  parameter int INT_LONG  = 16384,
  parameter int INT_SHORT = 1024,
  localparam int MAXW = (INT_LONG > EXT_POST) ? INT_LONG : EXT_POST,
  localparam int CW   = $clog2(MAXW + 1)
) (
  input  logic clk,
  input  logic arst_n,
  input  logic tick_en,
  input  logic supply_ok,
  input  logic kick_in,
  input  logic ext_base,
  input  logic long_sel,
  output logic sys_rst_n,
  output logic wd_ok
);
  import wdt_pkg::*;

  logic [1:0]    rsync_q;
  logic          rst_n;
  tbase_e        mode_q, mode_d;
  logic [CW-1:0] lim_post, lim_norm;
  logic          kick_edge, timeout, rst_act;
  logic [CW-1:0] wd_cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rsync_q <= 2'b00;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  always_comb begin
    mode_d = mode_q;
    if (supply_ok) mode_d = decode_mode(ext_base, long_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= TB_INT_LONG;
    else        mode_q <= mode_d;
  end

  always_comb begin
    unique case (mode_q)
      TB_EXT:       begin lim_post = CW'(EXT_POST); lim_norm = CW'(EXT_NORM);  end
      TB_INT_SHORT: begin lim_post = CW'(INT_LONG); lim_norm = CW'(INT_SHORT); end
      default:      begin lim_post = CW'(INT_LONG); lim_norm = CW'(INT_LONG);  end
    endcase
  end

  wdt_sync_edge u_kick (
    .clk(clk), .rst_n(rst_n), .din(kick_in), .en(supply_ok), .edge_o(kick_edge)
  );

  wdt_rst_timer #(.RST_TICKS(RST_TICKS)) u_rst (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .hold(!supply_ok),
    .start(timeout), .active(rst_act)
  );

  wdt_dog #(.CW(CW)) u_dog (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .supply_ok(supply_ok),
    .rst_act(rst_act), .kick_edge(kick_edge), .lim_post(lim_post),
    .lim_norm(lim_norm), .timeout(timeout), .wd_ok(wd_ok), .count_o(wd_cnt)
  );

  assign sys_rst_n = !rst_act;
endmodule

// File: rtl/wdt_supervisor_chk.sv
module wdt_supervisor_chk #(
  parameter int CW = 15
) (
  input logic          clk,
  input logic          arst_n,
  input logic          tick_en,
  input logic          supply_ok,
  input logic          sys_rst_n,
  input logic          wd_ok,
  input logic          kick_edge,
  input logic          rst_act,
  input logic [CW-1:0] wd_cnt
);
  // R1
  rst_low_unpowered_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !supply_ok |=> !sys_rst_n);

  // R8
  wdo_high_unpowered_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !supply_ok |=> wd_ok);

  // R6
  timeout_resets_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(wd_ok) |-> !sys_rst_n);

  // R7
  wdo_latched_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!wd_ok && supply_ok && !kick_edge) |=> !wd_ok);

  // R11
  idle_without_tick_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!tick_en && supply_ok && !kick_edge && !rst_act) |=> $stable(wd_cnt));

  // R11
  release_on_tick_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(sys_rst_n) |-> $past(tick_en));
endmodule

bind wdt_supervisor wdt_supervisor_chk #(.CW(CW)) u_chk (
  .clk(clk), .arst_n(arst_n), .tick_en(tick_en), .supply_ok(supply_ok),
  .sys_rst_n(sys_rst_n), .wd_ok(wd_ok), .kick_edge(kick_edge),
  .rst_act(rst_act), .wd_cnt(wd_cnt)
);

// File: tb/test_wdt_supervisor.sv
`timescale 1ns/1ps
module test_wdt_supervisor;
  localparam int RST = 512;

  logic clk = 1'b0;
  logic arst_n, tick_en, supply_ok, kick_in, ext_base, long_sel;
  logic sys_rst_n, wd_ok;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  always #5 clk = ~clk;

  wdt_supervisor i_wdt_supervisor (
    .clk(clk), .arst_n(arst_n), .tick_en(tick_en), .supply_ok(supply_ok),
    .kick_in(kick_in), .ext_base(ext_base), .long_sel(long_sel),
    .sys_rst_n(sys_rst_n), .wd_ok(wd_ok)
  );

  typedef struct packed {
    logic ext;
    logic lng;
    int   post;
    int   norm;
  } vec_t;

  localparam vec_t VECS [3] = '{
    '{1'b1, 1'b0, 4096,  1024},
    '{1'b0, 1'b1, 16384, 16384},
    '{1'b0, 1'b0, 16384, 1024}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wait_rst_high(output int n);
    n = 0;
    while (!sys_rst_n) begin step(); n++; end
  endtask

  task automatic wait_wdo(input logic lvl, inout int n);
    while (wd_ok !== lvl) begin step(); n++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    string rp, rn;
    arst_n = 0; tick_en = 1; supply_ok = 1; kick_in = 0; ext_base = 1; long_sel = 0;
    #23;
    // R12 asynchronous reset state
    check(sys_rst_n == 0, "R12 rst", sys_rst_n, 0);
    check(wd_ok == 1, "R12 wdo", wd_ok, 1);
    step(); arst_n = 1;
    wait_rst_high(n);

    foreach (VECS[i]) begin
      rp = (i == 0) ? "R2" : (i == 1) ? "R4" : "R5";
      rn = (i == 0) ? "R3" : (i == 1) ? "R4" : "R5";
      supply_ok = 0;
      repeat (3) step();
      check(sys_rst_n == 0, "R1 low while unpowered", sys_rst_n, 0);
      check(wd_ok == 1, "R8 wdo high while unpowered", wd_ok, 1);
      for (int k = 0; k < 6; k++) begin
        kick_in = ~kick_in; ext_base = ~ext_base; long_sel = k[0];
        step(); step();
        check(sys_rst_n == 0 && wd_ok == 1, "R9 ignored while unpowered",
              {sys_rst_n, wd_ok}, 1);
      end
      ext_base = VECS[i].ext; long_sel = VECS[i].lng;
      supply_ok = 1;
      wait_rst_high(n);
      check(n == RST, "R1 pulse after supply", n, RST);
      n = 0; wait_wdo(1'b0, n);
      check(n == VECS[i].post, rp, n, VECS[i].post);
      check(sys_rst_n == 0, "R6 reset on timeout", sys_rst_n, 0);
      wait_rst_high(n);
      check(n == RST, "R6 timeout pulse length", n, RST);
      repeat (5) step();
      check(wd_ok == 0, "R7 wdo stays low", wd_ok, 0);
      kick_in = ~kick_in;
      n = 0; wait_wdo(1'b1, n);
      check(n == 3, "R7 wdo rise latency", n, 3);
      wait_wdo(1'b0, n);
      check(n == VECS[i].norm + 3, rn, n, VECS[i].norm + 3);
      wait_rst_high(n);
    end

    // R10 both kick edges restart the window (external mode, window 1024)
    ext_base = 1;
    kick_in = ~kick_in;
    repeat (4) step();
    check(wd_ok == 1, "R10 wdo raised", wd_ok, 1);
    n = 0;
    for (int k = 0; k < 8; k++) begin
      for (int c = 0; c < 900; c++) begin
        step();
        if (!wd_ok || !sys_rst_n) n++;
      end
      kick_in = ~kick_in;
    end
    check(n == 0, "R10 no timeout with alternating kicks", n, 0);

    // R11 gated time base stretches the reset pulse
    supply_ok = 0;
    repeat (3) step();
    supply_ok = 1;
    n = 0;
    while (!sys_rst_n) begin tick_en = ~tick_en; step(); n++; end
    tick_en = 1;
    check(n >= 2*RST - 1 && n <= 2*RST + 1, "R11 gated tick", n, 2*RST);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule